// File: doc/BRIEF.md
# Link Diagnostic Status Register

This block keeps the diagnostic state of a copper Ethernet link and returns it to software through a small read port. It captures three things. The first is the polarity sensed on each of the four twisted pairs, which is reported only while a gigabit copper link is up. The second is a sticky flag that records a negotiation pulse exchange that completed while the link still failed to come up. The third is a control bit that turns off automatic polarity correction.

The negotiation logic and the link detector drive single-cycle event strobes and level inputs into the block. Software selects a register with an address, then either reads it with a read strobe or writes the control bit with a write strobe. Read data is registered and holds between reads. Reading the sticky flag clears it. The block also drives the effective polarity-correction enable and the per-pair polarity that the receive datapath applies.

Top module: `link_diag_status`

## Requirements
- R1: After reset the sticky flag is 0, the correction-disable bit is 0 (corr_en_o = 1), and rd_data_o is 0.
- R2: Address 0 returns the pair polarity in bits [3:0], bit i for pair i and 1 meaning reversed, while gig_link_i is 1. All upper bits are 0.
- R3: While gig_link_i is 0, a read of address 0 returns all zeros whatever pair_pol_i holds.
- R4: A cycle with an_done_i = 1 and link_up_i = 0 sets the sticky flag. The flag reads back as bit 0 of address 1.
- R5: The sticky flag is not set when an_done_i is 0, or when an_done_i is 1 while link_up_i is 1.
- R6: A set sticky flag is cleared only by a read of address 1. Reads of other addresses and writes leave it set.
- R7: If a set event and a read of address 1 occur in the same cycle, the read returns the old flag value and the flag ends at 1.
- R8: A write to address 2 stores wr_data_i[0] as the correction-disable bit, which reads back as bit 0 of address 2. While that bit is 1, corr_en_o is 0 and pol_eff_o is all zeros. While it is 0, pol_eff_o follows pair_pol_i.
- R9: Writes to addresses 0, 1 and 3 change no state.
- R10: Read data appears on rd_data_o one cycle after the read strobe and holds until the next strobe. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| an_done_i | input | 1 | Strobe: negotiation pulse exchange finished |
| link_up_i | input | 1 | Link established (level) |
| gig_link_i | input | 1 | Gigabit copper link up (level) |
| pair_pol_i | input | NUM_PAIRS | Sensed polarity per pair, 1 = reversed |
| addr_i | input | 2 | Register select: 0 polarity, 1 sticky, 2 control |
| rd_stb_i | input | 1 | Read strobe |
| wr_stb_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Registered read data |
| corr_en_o | output | 1 | Polarity correction enabled |
| pol_eff_o | output | NUM_PAIRS | Polarity applied by the datapath |

## Verification
The hardest case to reach from the ports is the collision between a set event and the clearing read in the same cycle. The flag has to be caught once while clear and once while already set, and its later state can only be seen through a second read. The bench puts the event pulse and the read strobe on the same edge and checks the returned value. A follow-up read then shows that the flag survived. The bench also sweeps every combination of the event and link inputs, and every polarity pattern with the gigabit link both up and down.

// File: rtl/lds_pkg.sv
package lds_pkg;
  typedef enum logic [1:0] {
    SEL_POL    = 2'd0,
    SEL_STICKY = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } sel_e;
endpackage

// File: rtl/lds_sticky.sv
module lds_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // set beats read-clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/lds_pol.sv
module lds_pol #(
  parameter int NUM_PAIRS = 4
) (
  input  logic                 gig_link_i,
  input  logic                 corr_dis_i,
  input  logic [NUM_PAIRS-1:0] pair_pol_i,
  output logic [NUM_PAIRS-1:0] pol_rpt_o,
  output logic [NUM_PAIRS-1:0] pol_eff_o
);
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pol_rpt_o[p] = gig_link_i & pair_pol_i[p];
    assign pol_eff_o[p] = ~corr_dis_i & pair_pol_i[p];
  end
endmodule

// File: rtl/lds_readmux.sv
module lds_readmux #(
  parameter int NUM_PAIRS = 4,
  parameter int DATA_W    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_stb_i,
  input  lds_pkg::sel_e        sel_i,
  input  logic [NUM_PAIRS-1:0] pol_rpt_i,
  input  logic                 sticky_i,
  input  logic                 corr_dis_i,
  output logic [DATA_W-1:0]    rd_data_o
);
  import lds_pkg::*;
  logic [DATA_W-1:0] mux_d;

  always_comb begin
    mux_d = '0;
    unique case (sel_i)
      SEL_POL:    mux_d[NUM_PAIRS-1:0] = pol_rpt_i;
      SEL_STICKY: mux_d[0] = sticky_i;
      SEL_CTRL:   mux_d[0] = corr_dis_i;
      default:    mux_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_data_o <= '0;
    else if (rd_stb_i) rd_data_o <= mux_d;
  end
endmodule

// File: rtl/link_diag_status.sv
module link_diag_status #(
  parameter int NUM_PAIRS = 4,
  parameter int DATA_W    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 an_done_i,
  input  logic                 link_up_i,
  input  logic                 gig_link_i,
  input  logic [NUM_PAIRS-1:0] pair_pol_i,
  input  logic [1:0]           addr_i,
  input  logic                 rd_stb_i,
  input  logic                 wr_stb_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 corr_en_o,
  output logic [NUM_PAIRS-1:0] pol_eff_o
);
  import lds_pkg::*;

  sel_e                 sel;
  logic                 set_ev, rd_clr, sticky_q, dis_q;
  logic [NUM_PAIRS-1:0] pol_rpt;
  logic                 unused_wr_hi;

  assign sel          = sel_e'(addr_i);
  assign set_ev       = an_done_i & ~link_up_i;
  assign rd_clr       = rd_stb_i & (sel == SEL_STICKY);
  assign unused_wr_hi = ^wr_data_i[DATA_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          dis_q <= 1'b0;
    else if (wr_stb_i && sel == SEL_CTRL) dis_q <= wr_data_i[0];
  end
  assign corr_en_o = ~dis_q;

  lds_sticky u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_ev),
    .clr_i  (rd_clr),
    .flag_o (sticky_q)
  );

  lds_pol #(.NUM_PAIRS(NUM_PAIRS)) u_pol (
    .gig_link_i (gig_link_i),
    .corr_dis_i (dis_q),
    .pair_pol_i (pair_pol_i),
    .pol_rpt_o  (pol_rpt),
    .pol_eff_o  (pol_eff_o)
  );

  lds_readmux #(.NUM_PAIRS(NUM_PAIRS), .DATA_W(DATA_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_stb_i   (rd_stb_i),
    .sel_i      (sel),
    .pol_rpt_i  (pol_rpt),
    .sticky_i   (sticky_q),
    .corr_dis_i (dis_q),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/lds_checker.sv
module lds_checker #(
  parameter int NUM_PAIRS = 4,
  parameter int DATA_W    = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 an_done_i,
  input logic                 link_up_i,
  input logic                 gig_link_i,
  input logic [1:0]           addr_i,
  input logic                 rd_stb_i,
  input logic                 wr_stb_i,
  input logic [DATA_W-1:0]    rd_data_o,
  input logic                 corr_en_o,
  input logic [NUM_PAIRS-1:0] pol_eff_o,
  input logic                 sticky_q
);
  AST_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_done_i && !link_up_i) |=> sticky_q);  // R4
  AST_STICKY_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sticky_q && !(an_done_i && !link_up_i)) |=> !sticky_q);  // R5
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_q && !(rd_stb_i && addr_i == 2'd1)) |=> sticky_q);  // R6
  AST_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && addr_i == 2'd1 && an_done_i && !link_up_i) |=> (sticky_q && rd_data_o[0] == $past(sticky_q)));  // R7
  AST_FORCE_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !corr_en_o |-> (pol_eff_o == '0));  // R8
  AST_CTRL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_i && addr_i == 2'd2) |=> $stable(corr_en_o));  // R9
  AST_POL_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && addr_i == 2'd0 && !gig_link_i) |=> (rd_data_o == '0));  // R3
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_i |=> $stable(rd_data_o));  // R10
endmodule

bind link_diag_status lds_checker #(.NUM_PAIRS(NUM_PAIRS), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .an_done_i  (an_done_i),
  .link_up_i  (link_up_i),
  .gig_link_i (gig_link_i),
  .addr_i     (addr_i),
  .rd_stb_i   (rd_stb_i),
  .wr_stb_i   (wr_stb_i),
  .rd_data_o  (rd_data_o),
  .corr_en_o  (corr_en_o),
  .pol_eff_o  (pol_eff_o),
  .sticky_q   (sticky_q)
);

// File: tb/link_diag_status_tb.sv
module link_diag_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          an_done_i = 1'b0, link_up_i = 1'b0, gig_link_i = 1'b0;
  logic [NP-1:0] pair_pol_i = '0;
  logic [1:0]    addr_i = '0;
  logic          rd_stb_i = 1'b0, wr_stb_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          corr_en_o;
  logic [NP-1:0] pol_eff_o;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  link_diag_status #(.NUM_PAIRS(NP), .DATA_W(DW)) u_dut (.*);

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // read: strobe for one edge, data sampled after the following negedge
  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk_i); addr_i = a; rd_stb_i = 1'b1;
    @(negedge clk_i); rd_stb_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] v);
    @(negedge clk_i); addr_i = a; wr_stb_i = 1'b1; wr_data_i = v;
    @(negedge clk_i); wr_stb_i = 1'b0;
  endtask

  task automatic ev(input logic dn, input logic lk);
    @(negedge clk_i); an_done_i = dn; link_up_i = lk;
    @(negedge clk_i); an_done_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 rd_data", rd_data_o, '0);
    check("R1 corr_en", {15'd0, corr_en_o}, 16'd1);
    rst_ni = 1'b1;
    rd(2'd1, d); check("R1 sticky", d, '0);
    rd(2'd2, d); check("R1 ctrl", d, '0);

    // R2 / R3 polarity sweep, gig up and down
    for (int g = 0; g < 2; g++) begin
      for (int p = 0; p < 16; p++) begin
        gig_link_i = g[0]; pair_pol_i = p[NP-1:0];
        rd(2'd0, d);
        if (g == 1) check("R2 pol", d, 16'(p));
        else        check("R3 pol masked", d, '0);
        check("R8 eff follows", {12'd0, pol_eff_o}, 16'(p));
      end
    end

    // R4 / R5 sticky over every event/link combination
    for (int dn = 0; dn < 2; dn++) begin
      for (int lk = 0; lk < 2; lk++) begin
        rd(2'd1, d);  // clear
        ev(dn[0], lk[0]);
        rd(2'd1, d);
        if (dn == 1 && lk == 0) check("R4 set", d, 16'd1);
        else                    check("R5 no set", d, '0);
        rd(2'd1, d); check("R6 cleared by read", d, '0);
      end
    end
    link_up_i = 1'b0;

    // R6 other reads and writes keep flag
    ev(1'b1, 1'b0);
    rd(2'd0, d); rd(2'd2, d); rd(2'd3, d);
    check("R10 addr3 zero", d, '0);
    wr(2'd1, '0); wr(2'd0, '0);
    rd(2'd1, d); check("R6 survives", d, 16'd1);

    // R7 collision from clear and from set
    for (int pre = 0; pre < 2; pre++) begin
      rd(2'd1, d);  // clear
      if (pre == 1) ev(1'b1, 1'b0);
      @(negedge clk_i); addr_i = 2'd1; rd_stb_i = 1'b1; an_done_i = 1'b1; link_up_i = 1'b0;
      @(negedge clk_i); rd_stb_i = 1'b0; an_done_i = 1'b0;
      check("R7 old value", rd_data_o, 16'(pre));
      rd(2'd1, d); check("R7 flag kept", d, 16'd1);
    end
    rd(2'd1, d);

    // R10 hold without strobe
    pair_pol_i = 4'hA; gig_link_i = 1'b1;
    rd(2'd0, d);
    pair_pol_i = 4'h5; gig_link_i = 1'b0; ev(1'b1, 1'b0);
    repeat (3) @(negedge clk_i);
    check("R10 hold", rd_data_o, 16'h000A);

    // R8 control write, R9 stray writes
    pair_pol_i = 4'hF;
    wr(2'd2, 16'hFFFF);
    check("R8 corr off", {15'd0, corr_en_o}, '0);
    check("R8 eff forced", {12'd0, pol_eff_o}, '0);
    rd(2'd2, d); check("R8 ctrl readback", d, 16'd1);
    wr(2'd0, '0); wr(2'd1, '0); wr(2'd3, '0);
    check("R9 ctrl unchanged", {15'd0, corr_en_o}, '0);
    wr(2'd2, 16'hFFFE);
    check("R8 corr on", {15'd0, corr_en_o}, 16'd1);
    check("R8 eff restored", {12'd0, pol_eff_o}, 16'h000F);
    wr(2'd0, 16'h0001); wr(2'd3, 16'h0001);
    check("R9 ctrl stays on", {15'd0, corr_en_o}, 16'd1);
    rd(2'd1, d); check("R9 sticky kept after writes", d, 16'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule